// File: doc/BRIEF.md
# DMA Pattern Generator and Checker

This block drives and verifies a data loop such as a DMA path. After a start pulse it sends one buffer of a selected byte pattern on a 32-bit valid/ready transmit stream. It then sends a buffer of all-zero words, flagged as scrub data, so that the receive side can be cleared. Last, it accepts the returned buffer on a receive stream and compares every word with the pattern expected at that offset. The three phases repeat for a parameter-set number of buffers, which together cover the target range.

The pattern is decoded from the byte offset inside the buffer, so no table is stored. Data is little-endian: byte offset 4k+n of the buffer sits in bits 8n+7:8n of word k. On the first mismatch the block records where it happened and what it saw, and then stops.

FSM states: `ST_IDLE` (after reset), `ST_SEND` (pattern words out), `ST_SCRUB` (zero words out), `ST_CHECK` (returned words in), `ST_PASS` (range covered without error) and `ST_FAIL` (mismatch captured). Transitions:
- IDLE, PASS or FAIL to SEND on `start`.
- SEND to SCRUB on the handshake of the last word.
- SCRUB to CHECK on the handshake of the last word.
- CHECK to SEND on a matching last word while buffers remain.
- CHECK to PASS on a matching last word of the final buffer.
- CHECK to FAIL on any mismatching word.

Top module: `pattern_dma_checker`

## Requirements
- R1: After reset `tx_valid`, `rx_ready`, `busy`, `done` and `fail` are all low.
- R2: A `start` pulse outside a run latches `pat_sel` and begins the transmit phase. Each phase moves BUF_BYTES/4 words. A word advances only on `tx_valid && tx_ready`. While a word is stalled, `tx_data` and `tx_last` hold. `tx_last` is high on the final word of each buffer.
- R3: Pattern codes 0 and 1 alternate runs of 16 bytes. Code 0 gives 0x00 where bit 4 of the byte offset is 0 and 0xFF where it is 1. Code 1 is the inverse of code 0. Codes 2 and 3 do the same on bit 5, giving 32-byte runs, with code 2 starting on 0x00 and code 3 starting on 0xFF.
- R4: Codes 4, 5, 6 and 7 fill every word with 0x00000000, 0xFFFFFFFF, 0xAA55AA55 and 0x55AA55AA respectively. Byte lane n of a word carries buffer byte 4k+n, so lane 0 of code 6 is 0x55.
- R5: After each pattern buffer comes a scrub buffer of the same length. Every scrub word is zero and has `tx_clear` high. Pattern words have `tx_clear` low.
- R6: `rx_ready` is high only in the check phase and `tx_valid` is low there. Each accepted word is compared with the pattern word for its offset.
- R7: After NUM_BUFS buffers pass, `done` goes high and `busy` goes low.
- R8: On the first mismatch, `fail` goes high. `fail_offset` is set to buffer index × BUF_BYTES + 4 × word index. `fail_got` and `fail_exp` are set to the received and expected words. The block then stops, with `rx_ready` and `tx_valid` low, and holds these values until the next start.
- R9: `start` during a run has no effect on the pattern or the sequence.
- R10: A new start clears `done` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle, passed or failed |
| pat_sel | input | 3 | Pattern code, latched on start |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Transmit word accepted |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of a buffer |
| tx_clear | output | 1 | Current word is scrub data |
| rx_valid | input | 1 | Returned word valid |
| rx_ready | output | 1 | Block accepts returned words |
| rx_data | input | 32 | Returned word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Range covered without mismatch |
| fail | output | 1 | Mismatch captured |
| fail_offset | output | log2(NUM_BUFS)+log2(BUF_BYTES) | Byte offset of the failing word in the range |
| fail_got | output | 32 | Received word at the mismatch |
| fail_exp | output | 32 | Expected word at the mismatch |

## Verification
The hardest case to reach is a mismatch late in the range: in the second buffer and partway through it, while both streams are being throttled. Only that case shows whether the captured offset combines the buffer index and the word index correctly. The bench models the loop itself. It returns the words it computes as correct, then flips one bit of a chosen word in a chosen buffer. It spaces the beats with deterministic stall gaps on `tx_ready` and `rx_valid`. A start pulse is also injected in the middle of a transmit phase, to show that a running sequence is not disturbed.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_SCRUB,
        ST_CHECK,
        ST_PASS,
        ST_FAIL
    } pgc_state_t;

    localparam int WORD_BYTES = 4;

    // One byte lane of the pattern. run16/run32 are bits 4/5 of the byte offset,
    // odd marks an odd byte lane (little-endian placement).
    function automatic logic [7:0] pgc_lane_byte(input logic [2:0] sel,
                                                 input logic       run16,
                                                 input logic       run32,
                                                 input logic       odd);
        logic [7:0] b;
        unique case (sel)
            3'd0: b = run16 ? 8'hFF : 8'h00;
            3'd1: b = run16 ? 8'h00 : 8'hFF;
            3'd2: b = run32 ? 8'hFF : 8'h00;
            3'd3: b = run32 ? 8'h00 : 8'hFF;
            3'd4: b = 8'h00;
            3'd5: b = 8'hFF;
            3'd6: b = odd ? 8'hAA : 8'h55;
            3'd7: b = odd ? 8'h55 : 8'hAA;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pgc_count.sv
module pgc_count #(
    parameter int WIDTH = 4,
    parameter int MAX   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] value,
    output logic             at_max
);
    assign at_max = (value == WIDTH'(MAX));

    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (clr)    value <= '0;
        else if (inc)    value <= at_max ? '0 : value + 1'b1;
    end

    // R2: counter wraps to zero after its last position
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_max && !clr) |=> (value == '0));
endmodule

// File: rtl/pgc_pattern.sv
module pgc_pattern #(
    parameter int WIDX_W = 10
) (
    input  logic [2:0]        sel,
    input  logic [WIDX_W-1:0] word_idx,
    output logic [31:0]       word
);
    import pgc_pkg::*;

    // byte offset = word_idx*4 + lane; bits 4 and 5 come from word_idx[2], [3]
    genvar lane;
    generate
        for (lane = 0; lane < WORD_BYTES; lane++) begin : g_lane
            assign word[8*lane +: 8] = pgc_lane_byte(sel, word_idx[2], word_idx[3],
                                                     (lane % 2) == 1);
        end
    endgenerate
endmodule

// File: rtl/pgc_match.sv
module pgc_match #(
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cmp_en,
    input  logic [31:0]      got,
    input  logic [31:0]      exp,
    input  logic [OFF_W-1:0] offset,
    output logic             miss,
    output logic             fail_q,
    output logic [OFF_W-1:0] off_q,
    output logic [31:0]      got_q,
    output logic [31:0]      exp_q
);
    assign miss = (got != exp);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail_q <= 1'b0;
            off_q  <= '0;
            got_q  <= '0;
            exp_q  <= '0;
        end else if (cmp_en && miss && !fail_q) begin
            fail_q <= 1'b1;
            off_q  <= offset;
            got_q  <= got;
            exp_q  <= exp;
        end
    end

    // R8: first mismatch captures offset and data
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && miss && !fail_q && !clr) |=>
            (fail_q && off_q == $past(offset) && got_q == $past(got)));
endmodule

// File: rtl/pattern_dma_checker.sv
module pattern_dma_checker #(
    parameter int BUF_BYTES = 4096,
    parameter int NUM_BUFS  = 4,
    localparam int WORDS    = BUF_BYTES / 4,
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int BIDX_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
    localparam int OFF_W    = BIDX_W + WIDX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       pat_sel,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    output logic             tx_clear,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [31:0]      rx_data,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [OFF_W-1:0] fail_offset,
    output logic [31:0]      fail_got,
    output logic [31:0]      fail_exp
);
    import pgc_pkg::*;

    pgc_state_t        state, state_nx;
    logic [2:0]        pat_q;
    logic [WIDX_W-1:0] word_idx;
    logic [BIDX_W-1:0] buf_idx;
    logic              wlast, blast, launch, beat_tx, beat_rx, miss;
    logic [31:0]       exp_word;
    logic [OFF_W-1:0]  cur_off;

    assign launch  = start && (state == ST_IDLE || state == ST_PASS || state == ST_FAIL);
    assign beat_tx = tx_valid && tx_ready;
    assign beat_rx = rx_valid && rx_ready;
    assign cur_off = {buf_idx, word_idx, 2'b00};

    pgc_count #(.WIDTH(WIDX_W), .MAX(WORDS - 1)) u_word (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .inc(beat_tx || (beat_rx && !miss)),
        .value(word_idx), .at_max(wlast)
    );

    pgc_count #(.WIDTH(BIDX_W), .MAX(NUM_BUFS - 1)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .inc(beat_rx && !miss && wlast),
        .value(buf_idx), .at_max(blast)
    );

    pgc_pattern #(.WIDX_W(WIDX_W)) u_pat (
        .sel(pat_q), .word_idx(word_idx), .word(exp_word)
    );

    pgc_match #(.OFF_W(OFF_W)) u_match (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .cmp_en(beat_rx), .got(rx_data), .exp(exp_word), .offset(cur_off),
        .miss(miss), .fail_q(fail), .off_q(fail_offset),
        .got_q(fail_got), .exp_q(fail_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pat_q <= '0;
        end else begin
            state <= state_nx;
            if (launch) pat_q <= pat_sel;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_PASS, ST_FAIL:
                if (start) state_nx = ST_SEND;
            ST_SEND:
                if (beat_tx && wlast) state_nx = ST_SCRUB;
            ST_SCRUB:
                if (beat_tx && wlast) state_nx = ST_CHECK;
            ST_CHECK:
                if (beat_rx) begin
                    if (miss)       state_nx = ST_FAIL;
                    else if (wlast) state_nx = blast ? ST_PASS : ST_SEND;
                end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_clear = 1'b0;
        tx_data  = '0;
        rx_ready = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_SEND:  begin tx_valid = 1'b1; tx_data = exp_word; busy = 1'b1; end
            ST_SCRUB: begin tx_valid = 1'b1; tx_clear = 1'b1;    busy = 1'b1; end
            ST_CHECK: begin rx_ready = 1'b1; busy = 1'b1; end
            ST_PASS:  done = 1'b1;
            default:  ;
        endcase
        tx_last = tx_valid && wlast;
    end

    // R2: a stalled word is held unchanged
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R5: scrub words are zero
    a_r5_scrub_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clear |-> (tx_data == 32'h0));

    // R6: the two streams are never active together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    // R8: the failure record is frozen until a new start
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_offset) && $stable(fail_got)
                              && !rx_ready && !tx_valid));
endmodule

// File: tb/sim_pattern_dma_checker.sv
module sim_pattern_dma_checker;
    localparam int BUF_BYTES = 128;
    localparam int NUM_BUFS  = 2;
    localparam int WORDS     = BUF_BYTES / 4;
    localparam int OFF_W     = 1 + $clog2(WORDS) + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       pat_sel = '0;
    logic             tx_valid, tx_last, tx_clear, rx_ready, busy, done, fail;
    logic             tx_ready = 1'b0;
    logic             rx_valid = 1'b0;
    logic [31:0]      rx_data = '0;
    logic [31:0]      tx_data, fail_got, fail_exp;
    logic [OFF_W-1:0] fail_offset;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    pattern_dma_checker #(.BUF_BYTES(BUF_BYTES), .NUM_BUFS(NUM_BUFS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_clear(tx_clear),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .busy(busy), .done(done), .fail(fail), .fail_offset(fail_offset),
        .fail_got(fail_got), .fail_exp(fail_exp)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    // expected word from byte offset (R3, R4); byte lane n = byte 4k+n
    function automatic logic [31:0] ref_word(input int p, input int off);
        logic [31:0] w;
        for (int n = 0; n < 4; n++) begin
            int bo = off + n;
            logic [7:0] b;
            case (p)
                0: b = ((bo / 16) % 2) ? 8'hFF : 8'h00;
                1: b = ((bo / 16) % 2) ? 8'h00 : 8'hFF;
                2: b = ((bo / 32) % 2) ? 8'hFF : 8'h00;
                3: b = ((bo / 32) % 2) ? 8'h00 : 8'hFF;
                4: b = 8'h00;
                5: b = 8'hFF;
                6: b = (n % 2) ? 8'hAA : 8'h55;
                default: b = (n % 2) ? 8'h55 : 8'hAA;
            endcase
            w[8*n +: 8] = b;
        end
        return w;
    endfunction

    task automatic run(input int p, input int bad_buf, input int bad_word, input bit poke);
        @(negedge clk);
        start = 1'b1; pat_sel = 3'(p);
        @(negedge clk);
        start = 1'b0;
        chk(!fail && !done && busy, "R10 start clears status", {29'd0, busy, done, fail}, 32'h4);
        for (int b = 0; b < NUM_BUFS; b++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int w = 0; w < WORDS; w++) begin
                    bit acc = 0;
                    while (!acc) begin
                        tx_ready = (cyc % 3) != 2;
                        if (poke && b == 0 && ph == 0 && w == 3) begin
                            start = 1'b1; pat_sel = ~3'(p);
                        end else start = 1'b0;
                        #1;
                        if (tx_valid && tx_ready) begin
                            acc = 1;
                            if (ph == 0) begin
                                chk(tx_data == ref_word(p, w * 4),
                                    poke ? "R9 pattern kept despite start" :
                                    (p < 4 ? "R3 run pattern word" : "R4 fill pattern word"),
                                    tx_data, ref_word(p, w * 4));
                                chk(!tx_clear, "R5 pattern word not flagged", {31'd0, tx_clear}, 0);
                            end else begin
                                chk(tx_data == 0 && tx_clear, "R5 scrub word zero",
                                    tx_data, 0);
                            end
                            chk(tx_last == (w == WORDS - 1), "R2 last flag", {31'd0, tx_last},
                                {31'd0, w == WORDS - 1});
                        end
                        @(negedge clk);
                    end
                end
            end
            tx_ready = 1'b0;
            chk(!tx_valid && rx_ready, "R6 check phase streams", {30'd0, tx_valid, rx_ready}, 1);
            for (int w = 0; w < WORDS; w++) begin
                bit acc = 0;
                bit bad = (b == bad_buf && w == bad_word);
                while (!acc) begin
                    rx_valid = (cyc % 4) != 1;
                    rx_data  = ref_word(p, w * 4) ^ (bad ? 32'h0000_0100 : 32'h0);
                    #1;
                    acc = rx_valid && rx_ready;
                    @(negedge clk);
                end
                if (bad) begin
                    rx_valid = 1'b0;
                    chk(fail && !done && !busy, "R8 fail raised", {29'd0, busy, done, fail}, 1);
                    chk(fail_offset == OFF_W'(b * BUF_BYTES + w * 4), "R8 offset",
                        32'(fail_offset), b * BUF_BYTES + w * 4);
                    chk(fail_got == (ref_word(p, w * 4) ^ 32'h100), "R8 got word", fail_got,
                        ref_word(p, w * 4) ^ 32'h100);
                    chk(fail_exp == ref_word(p, w * 4), "R8 expected word", fail_exp,
                        ref_word(p, w * 4));
                    repeat (3) @(negedge clk);
                    chk(!rx_ready && !tx_valid && fail_offset == OFF_W'(b * BUF_BYTES + w * 4),
                        "R8 stopped and held", {30'd0, rx_ready, tx_valid}, 0);
                    return;
                end
            end
            rx_valid = 1'b0;
        end
        chk(done && !busy && !fail, "R7 done after range", {29'd0, busy, done, fail}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tx_valid && !rx_ready && !busy && !done && !fail, "R1 reset state",
            {27'd0, tx_valid, rx_ready, busy, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !rx_ready && !busy && !done && !fail, "R1 idle after reset",
            {27'd0, tx_valid, rx_ready, busy, done, fail}, 0);
        for (int p = 0; p < 8; p++) run(p, -1, -1, p == 1);
        run(2, 1, 5, 0);
        run(3, 0, 0, 0);
        run(6, -1, -1, 0);
        summary();
    end
endmodule